// File: doc/BRIEF.md
# Signed Booth Multiply-Accumulate Unit

This block multiplies two 8-bit two's-complement operands and adds each product into a 20-bit running total. The multiplier operand is recoded into radix-4 Booth digits, which gives four partial products instead of eight. The running total is kept as a pair of vectors, a sum and a carry. Both vectors enter the same carry-save reduction as the partial products. No adder sits between a finished product and the accumulator. A single carry-propagate adder turns the stored pair into a plain binary value, and that value is registered on the output.

The unit is fed one operand pair per clock while `validIn` is high. `clrIn` starts a new total. With `validIn` high, the total restarts from the current product. With `validIn` low, the total restarts from zero. When both strobes are low, the state holds. The total wraps modulo 2^20. That width holds at least sixteen full-scale products before it can overflow.

Top module: `booth_mac_top`

## Requirements
- R1: After reset the output `accOut` is zero, and it stays zero until an operation is applied.
- R2: Each product is the signed value `mulA * mulB` of the two operands read as two's-complement numbers, sign-extended to 20 bits.
- R3: On a clock edge with `validIn` high and `clrIn` low, the signed product of the operands is added to the running total.
- R4: On a clock edge with both `validIn` and `clrIn` low, the running total is unchanged, and so is `accOut` from the following edge on.
- R5: On a clock edge with `clrIn` high and `validIn` low, the running total becomes zero. The operand values have no effect.
- R6: On a clock edge with both `clrIn` and `validIn` high, the running total becomes the current product alone. The previous total is discarded.
- R7: The operands sampled on clock edge k appear in `accOut` after edge k+1, and not earlier.
- R8: The running total wraps modulo 2^20. Adding 16384 forty times from a cleared state gives 0xA0000.
- R9: Every Booth digit value gives the right product, -2, -1, 0, +1 and +2 alike. This includes the operand extremes -128 and 127 on either input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Accumulate the current operand pair on this edge |
| clrIn | input | 1 | Restart the running total on this edge |
| mulA | input | 8 | Multiplicand, two's complement |
| mulB | input | 8 | Multiplier, two's complement, Booth-recoded |
| accOut | output | 20 | Resolved running total, registered |

## Verification
The state is held only in redundant form. A corrupted sum or carry bit, or a wrong Booth digit, therefore shows at `accOut` exactly two edges after the faulty operation. The error then stays in every later total until the next clear, so a long stream of random operations with occasional clears exposes it at the next compare. Faults in the strobe decoding show up right after an idle cycle or a clear: the value either moves when it should hold, or keeps history when it should restart. A fault in the carry shift or at the top bits shows up only near the operand extremes and at the wrap point, which is why directed cases target those.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

  localparam int OP_W  = 8;
  localparam int ACC_W = 20;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;   // state registers take the tree output
    logic keepAcc;  // feed the stored sum/carry back into the tree
    logic usePP;    // partial products are live (otherwise zero)
    logic outEn;    // resolve the state into the output register
  } macCtrl_t;

  // one radix-4 Booth digit
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } boothDig_t;

endpackage

// File: rtl/booth_mac_ctrl.sv
module booth_mac_ctrl
  import booth_mac_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     validIn,
  input  logic     clrIn,
  output macCtrl_t ctrl
);

  logic pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= validIn | clrIn;
  end

  always_comb begin
    ctrl.loadEn  = validIn | clrIn;
    ctrl.keepAcc = ~clrIn;
    ctrl.usePP   = validIn;
    ctrl.outEn   = pendQ;
  end

  AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (validIn || clrIn) |=> ctrl.outEn); // R7

  AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (!validIn && !clrIn) |=> !ctrl.outEn); // R4

endmodule

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mac_pkg::*;
#(
  parameter int OpW = OP_W,
  localparam int DigN = OpW / 2
) (
  input  logic [OpW-1:0]             mulB,
  output boothDig_t [DigN-1:0]       digs
);

  logic [OpW:0] extB;
  assign extB = {mulB, 1'b0};

  for (genvar i = 0; i < DigN; i++) begin : gDig
    logic [2:0] trip;
    assign trip = extB[2*i+2 -: 3];
    assign digs[i].one = trip[1] ^ trip[0];
    assign digs[i].two = (trip == 3'b011) | (trip == 3'b100);
    assign digs[i].neg = trip[2] & ~(trip[1] & trip[0]);
  end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_mac_pkg::*;
#(
  parameter int OpW  = OP_W,
  parameter int AccW = ACC_W,
  localparam int DigN = OpW / 2,
  localparam int ExtW = AccW - OpW - 1
) (
  input  logic [OpW-1:0]              mulA,
  input  boothDig_t [DigN-1:0]        digs,
  input  logic                        usePP,
  output logic [DigN-1:0][AccW-1:0]   rows,
  output logic [AccW-1:0]             negRow
);

  logic [DigN-1:0] negVec;

  for (genvar i = 0; i < DigN; i++) begin : gPp
    logic [OpW:0] sel;
    logic [OpW:0] inv;
    logic         negEff;
    logic         signE;
    logic [AccW-1:0] ext;

    always_comb begin
      sel = '0;
      if (usePP && digs[i].one)      sel = {mulA[OpW-1], mulA};
      else if (usePP && digs[i].two) sel = {mulA, 1'b0};
      negEff = usePP & digs[i].neg;
      // one's complement now, +1 injected through negRow
      inv   = sel ^ {(OpW+1){negEff}};
      signE = inv[OpW];
      ext   = {{ExtW{signE}}, inv};
    end

    assign rows[i]   = ext << (2 * i);
    assign negVec[i] = negEff;
  end

  always_comb begin
    negRow = '0;
    for (int k = 0; k < DigN; k++) negRow[2*k] = negVec[k];
  end

endmodule

// File: rtl/csa_chain.sv
module csa_chain #(
  parameter int AccW = 20,
  parameter int RowN = 7,
  localparam int StageN = RowN - 2
) (
  input  logic [RowN-1:0][AccW-1:0] rows,
  output logic [AccW-1:0]           sumV,
  output logic [AccW-1:0]           carryV
);

  logic [AccW-1:0] sArr [StageN];
  logic [AccW-1:0] cArr [StageN];

  for (genvar k = 0; k < StageN; k++) begin : gStage
    logic [AccW-1:0] x, y, z, maj;
    if (k == 0) begin : gFirst
      assign x = rows[0];
      assign y = rows[1];
    end else begin : gNext
      assign x = sArr[k-1];
      assign y = cArr[k-1];
    end
    assign z       = rows[k+2];
    assign maj     = (x & y) | (x & z) | (y & z);
    assign sArr[k] = x ^ y ^ z;
    assign cArr[k] = {maj[AccW-2:0], 1'b0};
  end

  assign sumV   = sArr[StageN-1];
  assign carryV = cArr[StageN-1];

endmodule

// File: rtl/booth_mac_dp.sv
module booth_mac_dp
  import booth_mac_pkg::*;
#(
  parameter int OpW  = OP_W,
  parameter int AccW = ACC_W,
  localparam int DigN = OpW / 2,
  localparam int RowN = DigN + 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  macCtrl_t        ctrl,
  input  logic [OpW-1:0]  mulA,
  input  logic [OpW-1:0]  mulB,
  output logic [AccW-1:0] accOut
);

  boothDig_t [DigN-1:0]      digs;
  logic [DigN-1:0][AccW-1:0] ppRows;
  logic [AccW-1:0]           negRow;
  logic [RowN-1:0][AccW-1:0] treeRows;
  logic [AccW-1:0]           treeSum, treeCarry;
  logic [AccW-1:0]           accSumQ, accCarryQ, accOutQ;
  logic [AccW-1:0]           resolved;
  logic signed [AccW-1:0]    prodRef;

  booth_recoder #(.OpW(OpW)) uRec (
    .mulB (mulB),
    .digs (digs)
  );

  booth_pp_gen #(.OpW(OpW), .AccW(AccW)) uPp (
    .mulA   (mulA),
    .digs   (digs),
    .usePP  (ctrl.usePP),
    .rows   (ppRows),
    .negRow (negRow)
  );

  always_comb begin
    for (int k = 0; k < DigN; k++) treeRows[k] = ppRows[k];
    treeRows[DigN]   = negRow;
    treeRows[DigN+1] = ctrl.keepAcc ? accSumQ   : '0;
    treeRows[DigN+2] = ctrl.keepAcc ? accCarryQ : '0;
  end

  csa_chain #(.AccW(AccW), .RowN(RowN)) uTree (
    .rows   (treeRows),
    .sumV   (treeSum),
    .carryV (treeCarry)
  );

  // final carry-propagate adder
  assign resolved = accSumQ + accCarryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSumQ   <= '0;
      accCarryQ <= '0;
      accOutQ   <= '0;
    end else begin
      if (ctrl.loadEn) begin
        accSumQ   <= treeSum;
        accCarryQ <= treeCarry;
      end
      if (ctrl.outEn) accOutQ <= resolved;
    end
  end

  assign accOut = accOutQ;

  // reference product for the checks below
  assign prodRef = AccW'($signed(mulA) * $signed(mulB));

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadEn |=> ($stable(accSumQ) && $stable(accCarryQ))); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadEn && !ctrl.keepAcc && !ctrl.usePP) |=> (resolved == '0)); // R5

  AST_FRESH_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadEn && !ctrl.keepAcc && ctrl.usePP) |=> (resolved == $past(prodRef))); // R6

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadEn && ctrl.keepAcc && ctrl.usePP) |=> (resolved == $past(resolved + prodRef))); // R3

endmodule

// File: rtl/booth_mac_top.sv
module booth_mac_top
  import booth_mac_pkg::*;
#(
  parameter int OpW  = OP_W,
  parameter int AccW = ACC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            validIn,
  input  logic            clrIn,
  input  logic [OpW-1:0]  mulA,
  input  logic [OpW-1:0]  mulB,
  output logic [AccW-1:0] accOut
);

  macCtrl_t ctrl;

  booth_mac_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .clrIn   (clrIn),
    .ctrl    (ctrl)
  );

  booth_mac_dp #(.OpW(OpW), .AccW(AccW)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .mulA   (mulA),
    .mulB   (mulB),
    .accOut (accOut)
  );

endmodule

// File: tb/sim_booth_mac_top.sv
module sim_booth_mac_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic        clrIn = 1'b0;
  logic [7:0]  mulA = '0;
  logic [7:0]  mulB = '0;
  logic [19:0] accOut;

  int checks = 0;
  int errors = 0;

  logic [19:0] refAcc = '0;
  logic [19:0] refLag = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  booth_mac_top u0 (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .clrIn   (clrIn),
    .mulA    (mulA),
    .mulB    (mulB),
    .accOut  (accOut)
  );

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: accOut=%0d (0x%05h) expected=%0d (0x%05h)",
               req, $signed(act), act, $signed(exp), exp);
    end
  endtask

  // called at a negedge; applies one operation and checks the lagged output
  task automatic step(input logic v, input logic c, input logic [7:0] a,
                      input logic [7:0] b, input string req);
    logic [19:0] prod;
    validIn = v; clrIn = c; mulA = a; mulB = b;
    @(posedge clk);
    prod   = 20'($signed(a) * $signed(b));
    refLag = refAcc;
    if (c)      refAcc = v ? prod : 20'd0;
    else if (v) refAcc = refAcc + prod;
    @(negedge clk);
    chk(req, accOut, refLag);
  endtask

  task automatic idle(input string req);
    step(1'b0, 1'b0, 8'h00, 8'h00, req);
  endtask

  task automatic tReset;
    chk("R1 reset", accOut, 20'd0);
    idle("R1 after reset");
    idle("R1 after reset");
  endtask

  task automatic tLatency;
    step(1'b1, 1'b1, 8'd3, 8'd5, "R7 first edge");
    chk("R7 not early", accOut, 20'd0);
    idle("R7 second edge");
    chk("R7 product 15", accOut, 20'd15);
  endtask

  task automatic tAccum;
    step(1'b1, 1'b0, 8'd10, 8'd10, "R3 add 100");
    step(1'b1, 1'b0, 8'hF6, 8'd7, "R3 add -70");
    step(1'b1, 1'b0, 8'hFD, 8'hFC, "R3 add 12");
    idle("R3 settle");
    chk("R3 sum 57", accOut, 20'd57);
  endtask

  task automatic tIdle;
    step(1'b0, 1'b0, 8'd99, 8'd99, "R4 idle ops ignored");
    step(1'b0, 1'b0, 8'h80, 8'h80, "R4 idle ops ignored");
    chk("R4 held", accOut, 20'd57);
  endtask

  task automatic tClearIdle;
    step(1'b0, 1'b1, 8'd77, 8'd66, "R5 clear");
    idle("R5 settle");
    chk("R5 zero", accOut, 20'd0);
  endtask

  task automatic tClearValid;
    step(1'b1, 1'b0, 8'd50, 8'd50, "R6 preload");
    step(1'b1, 1'b1, 8'hF9, 8'd6, "R6 clear with product");
    idle("R6 settle");
    chk("R6 product alone", accOut, 20'hFFFD6);
  endtask

  task automatic tExtremes;
    logic [7:0] vals [8] = '{8'h80, 8'h7F, 8'hFF, 8'h01, 8'h00, 8'h55, 8'hAA, 8'h33};
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        step(1'b1, 1'b1, vals[i], vals[j], "R9 pair");
        idle("R2 R9 single product");
      end
    end
    step(1'b1, 1'b1, 8'h80, 8'h80, "R9 -128*-128");
    idle("R9 settle");
    chk("R9 16384", accOut, 20'd16384);
    step(1'b1, 1'b1, 8'h80, 8'h7F, "R9 -128*127");
    idle("R9 settle");
    chk("R9 -16256", accOut, 20'hFC080);
  endtask

  task automatic tWrap;
    step(1'b1, 1'b1, 8'h80, 8'h80, "R8 start");
    for (int i = 0; i < 39; i++) step(1'b1, 1'b0, 8'h80, 8'h80, "R8 run");
    idle("R8 settle");
    chk("R8 wrapped 0xA0000", accOut, 20'hA0000);
  endtask

  task automatic tRandom;
    for (int i = 0; i < 400; i++) begin
      logic v, c;
      logic [7:0] a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[7:0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr[15:8];
      v = lfsr[0] | lfsr[3];
      c = (lfsr[6:3] == 4'hF);
      step(v, c, a, b, "R3 random stream");
    end
    idle("R3 random settle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: accOut=%0d expected=finish", accOut);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLatency();
    tAccum();
    tIdle();
    tClearIdle();
    tClearValid();
    tExtremes();
    tWrap();
    tRandom();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule